// File: doc/BRIEF.md
# Power Gating Domain Sequencer

This always-on controller shuts down and brings back one power-gated domain. A sleep request puts the domain to sleep in three steps. The outputs of the domain are clamped first. The retention registers are then told to save their contents. Only after that are the header switch segments turned off. A wake request turns the segments back on one at a time in daisy-chain order, and each segment must acknowledge before the next one is enabled. This keeps the inrush current low while the domain charges. Once the final segment acknowledges, the retention registers are told to restore, and the outputs are then unclamped.

Each segment must acknowledge within a limit that is set on an input port. If a segment does not acknowledge in time, the sequencer stops, leaves the switches as they are and raises a fault flag that stays set until reset. The block also contains the clamp that holds the domain's outputs. A clamped bit is the OR of the data bit and the isolation enable, so a clamped output reads 1.

The state machine has seven states. ON means the domain is powered and running. ISOLATE, SAVE and OFF are the shutdown steps and the sleep state. RAMP walks through the segments. RESTORE is the one-cycle restore pulse. FAULT means a segment timed out.

The transitions are:
- ON→ISOLATE when a sleep request is live or held.
- ISOLATE→SAVE and SAVE→OFF unconditionally.
- OFF→RAMP when a wake request is seen.
- RAMP→RAMP to the next segment when the current segment acknowledges.
- RAMP→RESTORE when the last segment acknowledges.
- RAMP→FAULT when the acknowledge limit expires.
- RESTORE→ON unconditionally.

Top module: `pgate_seq`

## Requirements
- R1: After reset the domain is powered. Every bit of seg_en is 1, iso_en is 0, save and restore are 0, dom_ready is 1 and fault is 0.
- R2: A sleep request seen in ON raises iso_en on the next cycle. save is high on the cycle after that. On the following cycle seg_en goes to all zeros while iso_en stays 1.
- R3: save and restore are active high. Each is a single-cycle pulse, and the two are never high together. save is only high while iso_en is 1 and all segments are enabled.
- R4: On wakeup, bit 0 of seg_en is enabled first. Bit k (k>0) is only enabled after seg_ack[k-1] was high on the previous cycle. seg_en always has the form of ones from bit 0 upward.
- R5: The cycle after the acknowledge of the last segment is a one-cycle restore pulse, with iso_en high and every segment enabled. On the next cycle iso_en is 0 and dom_ready is 1.
- R6: Let L be the value of ack_limit. If a segment has not acknowledged by the (L+1)th edge after it was enabled, fault rises on that edge. An acknowledge that arrives on that same edge is accepted. Once fault is set it stays set until reset, and seg_en stays frozen.
- R7: data_out equals data_in while iso_en is 0. Every bit of data_out is 1 while iso_en is 1.
- R8: A sleep request during wakeup is held. The domain still finishes waking, shows dom_ready for one cycle, and then begins shutdown without a new request.
- R9: A wake request while the domain is ON has no effect. A sleep request while the domain is OFF has no effect.
- R10: dom_ready is high only when iso_en is 0, every segment is enabled, and fault is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Request to power the domain down |
| wake_req | input | 1 | Request to power the domain up |
| ack_limit | input | LIM_W | Per-segment acknowledge limit, in cycles |
| seg_ack | input | N_SEG | Per-segment switch-on acknowledge |
| data_in | input | DATA_W | Outputs coming from the gated domain |
| seg_en | output | N_SEG | Header switch segment enables |
| iso_en | output | 1 | Isolation clamp enable |
| save | output | 1 | Retention save pulse |
| restore | output | 1 | Retention restore pulse |
| dom_ready | output | 1 | Domain powered and unclamped |
| fault | output | 1 | Sticky acknowledge-timeout flag |
| data_out | output | DATA_W | Clamped domain outputs |

## Verification
Two events can meet on one clock edge. The first is the acknowledge from the segment under test. The second is the expiry of that segment's limit. The bench provokes this by setting the model's acknowledge delay equal to ack_limit. The bench judges the result correct if the wakeup completes with a restore pulse and no fault. A delay one cycle longer must give fault on exactly the (L+1)th edge. A second overlap is tested by sending a sleep request while the segments are still ramping. That request must wait until dom_ready has been shown for one cycle before isolation rises again.

// File: rtl/pgate_pkg.sv
package pgate_pkg;

    typedef enum logic [2:0] {
        PG_ON,
        PG_ISO,
        PG_SAVE,
        PG_OFF,
        PG_RAMP,
        PG_RESTORE,
        PG_FAULT
    } pg_state_e;

endpackage

// File: rtl/pgate_ack_timer.sv
// Counts cycles while a segment waits for its acknowledge.
module pgate_ack_timer #(
    parameter int LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [LIM_W-1:0] limit,
    output logic             hit
);
    logic [LIM_W-1:0] cnt_q;

    assign hit = (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run && !hit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pgate_seg_mask.sv
// Ones from bit 0 up to and including the active segment index.
module pgate_seg_mask #(
    parameter int N_SEG = 4,
    parameter int IDX_W = 2
) (
    input  logic [IDX_W-1:0] idx,
    output logic [N_SEG-1:0] mask
);
    for (genvar g = 0; g < N_SEG; g++) begin : g_bit
        assign mask[g] = (idx >= IDX_W'(g));
    end
endmodule

// File: rtl/pgate_clamp.sv
// Clamps each output bit of the gated domain to 1 while isolation is on.
module pgate_clamp #(
    parameter int DATA_W = 8
) (
    input  logic              iso_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    for (genvar g = 0; g < DATA_W; g++) begin : g_bit
        assign dout[g] = din[g] | iso_en;
    end
endmodule

// File: rtl/pgate_fsm.sv
module pgate_fsm
    import pgate_pkg::*;
#(
    parameter int N_SEG = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic             wake_req,
    input  logic [N_SEG-1:0] seg_ack,
    input  logic [N_SEG-1:0] ramp_mask,
    input  logic             tmo_hit,
    output logic [IDX_W-1:0] idx,
    output logic             tmo_run,
    output logic             tmo_clr,
    output logic [N_SEG-1:0] seg_en,
    output logic             iso_en,
    output logic             save,
    output logic             restore,
    output logic             dom_ready,
    output logic             fault
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_SEG - 1);

    pg_state_e        state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             pend_q, pend_d;
    logic             cur_ack;

    assign cur_ack = seg_ack[idx_q];
    assign idx     = idx_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PG_ON;
            idx_q   <= LAST_IDX;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            pend_q  <= pend_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        pend_d  = pend_q;
        unique case (state_q)
            PG_ON: begin
                if (sleep_req || pend_q) begin
                    state_d = PG_ISO;
                    pend_d  = 1'b0;
                end
            end
            PG_ISO:  state_d = PG_SAVE;
            PG_SAVE: state_d = PG_OFF;
            PG_OFF: begin
                if (wake_req) begin
                    state_d = PG_RAMP;
                    idx_d   = '0;
                end
            end
            PG_RAMP: begin
                if (sleep_req) pend_d = 1'b1;
                if (cur_ack) begin
                    if (idx_q == LAST_IDX) state_d = PG_RESTORE;
                    else                   idx_d   = idx_q + 1'b1;
                end else if (tmo_hit) begin
                    state_d = PG_FAULT;
                end
            end
            PG_RESTORE: begin
                if (sleep_req) pend_d = 1'b1;
                state_d = PG_ON;
            end
            PG_FAULT: state_d = PG_FAULT;
            default:  state_d = PG_FAULT;
        endcase
    end

    // Outputs
    always_comb begin
        seg_en    = '1;
        iso_en    = 1'b1;
        save      = 1'b0;
        restore   = 1'b0;
        dom_ready = 1'b0;
        fault     = 1'b0;
        tmo_run   = 1'b0;
        tmo_clr   = 1'b1;
        unique case (state_q)
            PG_ON: begin
                iso_en    = 1'b0;
                dom_ready = 1'b1;
            end
            PG_ISO:  ;
            PG_SAVE: save = 1'b1;
            PG_OFF:  seg_en = '0;
            PG_RAMP: begin
                seg_en  = ramp_mask;
                tmo_run = 1'b1;
                tmo_clr = cur_ack;
            end
            PG_RESTORE: restore = 1'b1;
            PG_FAULT: begin
                seg_en = ramp_mask;
                fault  = 1'b1;
            end
            default: fault = 1'b1;
        endcase
    end
endmodule

// File: rtl/pgate_seq.sv
module pgate_seq #(
    parameter int N_SEG  = 4,
    parameter int DATA_W = 8,
    parameter int LIM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_req,
    input  logic              wake_req,
    input  logic [LIM_W-1:0]  ack_limit,
    input  logic [N_SEG-1:0]  seg_ack,
    input  logic [DATA_W-1:0] data_in,
    output logic [N_SEG-1:0]  seg_en,
    output logic              iso_en,
    output logic              save,
    output logic              restore,
    output logic              dom_ready,
    output logic              fault,
    output logic [DATA_W-1:0] data_out
);
    localparam int IDX_W = (N_SEG > 1) ? $clog2(N_SEG) : 1;

    logic [IDX_W-1:0] idx;
    logic [N_SEG-1:0] ramp_mask;
    logic             tmo_run, tmo_clr, tmo_hit;

    pgate_fsm #(.N_SEG(N_SEG), .IDX_W(IDX_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .wake_req  (wake_req),
        .seg_ack   (seg_ack),
        .ramp_mask (ramp_mask),
        .tmo_hit   (tmo_hit),
        .idx       (idx),
        .tmo_run   (tmo_run),
        .tmo_clr   (tmo_clr),
        .seg_en    (seg_en),
        .iso_en    (iso_en),
        .save      (save),
        .restore   (restore),
        .dom_ready (dom_ready),
        .fault     (fault)
    );

    pgate_seg_mask #(.N_SEG(N_SEG), .IDX_W(IDX_W)) u_mask (
        .idx  (idx),
        .mask (ramp_mask)
    );

    pgate_ack_timer #(.LIM_W(LIM_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmo_clr),
        .run   (tmo_run),
        .limit (ack_limit),
        .hit   (tmo_hit)
    );

    pgate_clamp #(.DATA_W(DATA_W)) u_clamp (
        .iso_en (iso_en),
        .din    (data_in),
        .dout   (data_out)
    );
endmodule

// File: rtl/pgate_seq_chk.sv
module pgate_seq_chk #(
    parameter int N_SEG  = 4,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SEG-1:0]  seg_ack,
    input logic [N_SEG-1:0]  seg_en,
    input logic              iso_en,
    input logic              save,
    input logic              restore,
    input logic              dom_ready,
    input logic              fault,
    input logic [DATA_W-1:0] data_out
);
    a_r2_iso_before_save: assert property (@(posedge clk) disable iff (!rst_n)
        save |-> $past(iso_en) && iso_en);

    a_r2_cut_after_save: assert property (@(posedge clk) disable iff (!rst_n)
        save |=> (seg_en == '0) && iso_en && !save);

    a_r3_save_all_on: assert property (@(posedge clk) disable iff (!rst_n)
        save |-> (&seg_en));

    a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({save, restore}));

    for (genvar g = 1; g < N_SEG; g++) begin : g_chain
        a_r4_daisy: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(seg_en[g]) && !(&seg_en) |-> $past(seg_ack[g-1]));
    end

    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> !iso_en && dom_ready && !restore);

    a_r5_restore_iso: assert property (@(posedge clk) disable iff (!rst_n)
        restore |-> iso_en && (&seg_en));

    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault && $stable(seg_en));

    a_r7_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        iso_en |-> (&data_out));

    a_r10_ready: assert property (@(posedge clk) disable iff (!rst_n)
        dom_ready |-> !iso_en && (&seg_en) && !fault);
endmodule

bind pgate_seq pgate_seq_chk #(.N_SEG(N_SEG), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .seg_ack   (seg_ack),
    .seg_en    (seg_en),
    .iso_en    (iso_en),
    .save      (save),
    .restore   (restore),
    .dom_ready (dom_ready),
    .fault     (fault),
    .data_out  (data_out)
);

// File: tb/pgate_seq_bench.sv
module pgate_seq_bench;
    localparam int N  = 4;
    localparam int DW = 8;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sleep_req, wake_req;
    logic [LW-1:0] ack_limit;
    logic [N-1:0]  seg_ack;
    logic [DW-1:0] data_in;
    logic [N-1:0]  seg_en;
    logic          iso_en, save, restore, dom_ready, fault;
    logic [DW-1:0] data_out;

    int checks = 0;
    int fails  = 0;
    int ack_dly;
    int dead_seg;
    int acnt [N];

    always #2 clk = ~clk;

    pgate_seq #(.N_SEG(N), .DATA_W(DW), .LIM_W(LW)) u_pgate_seq (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
        .ack_limit(ack_limit), .seg_ack(seg_ack), .data_in(data_in),
        .seg_en(seg_en), .iso_en(iso_en), .save(save), .restore(restore),
        .dom_ready(dom_ready), .fault(fault), .data_out(data_out)
    );

    // Switch segment model: acknowledges ack_dly edges after being enabled
    always @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!seg_en[i]) begin
                acnt[i]    <= 0;
                seg_ack[i] <= 1'b0;
            end else begin
                acnt[i]    <= acnt[i] + 1;
                seg_ack[i] <= (i != dead_seg) && (acnt[i] + 1 >= ack_dly);
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; sleep_req = 0; wake_req = 0;
        ack_limit = 8'd8; ack_dly = 2; dead_seg = -1; data_in = 8'h5A;
        for (int i = 0; i < N; i++) acnt[i] = 0;
        seg_ack = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_reset();
        check(seg_en == 4'hF, "R1 seg_en", 32'(seg_en), 32'hF);
        check(iso_en == 0, "R1 iso_en", 32'(iso_en), 0);
        check(!save && !restore, "R1 save/restore", 32'({save, restore}), 0);
        check(dom_ready == 1, "R1 dom_ready", 32'(dom_ready), 1);
        check(fault == 0, "R1 fault", 32'(fault), 0);
        check(data_out == data_in, "R7 pass-through", 32'(data_out), 32'(data_in));
    endtask

    task automatic t_shutdown();
        sleep_req = 1; tick(); sleep_req = 0;
        check(iso_en && !save && seg_en == 4'hF, "R2 isolate step",
              32'({iso_en, save, seg_en}), 32'h2F);
        tick();
        check(save && iso_en && seg_en == 4'hF, "R3 save pulse",
              32'({iso_en, save, seg_en}), 32'h3F);
        tick();
        check(!save && iso_en && seg_en == 0 && !dom_ready, "R2 switches off",
              32'({iso_en, save, seg_en}), 32'h20);
        data_in = 8'h24;
        check(data_out == 8'hFF, "R7 clamp to ones", 32'(data_out), 32'hFF);
        tick();
        check(!save && seg_en == 0, "R3 save single cycle", 32'({save, seg_en}), 0);
    endtask

    // Wake from OFF; optionally pulse sleep_req on the third ramp cycle.
    task automatic t_wake(input bit inject, input string tag);
        logic [N-1:0] prev_en, prev_ack;
        int viol = 0, rcount = 0;
        bit seen = 0, prev_rest = 0, rest_ok = 1;
        prev_en = seg_en; prev_ack = seg_ack;
        wake_req = 1; tick(); wake_req = 0;
        for (int c = 0; c < 400 && !seen; c++) begin
            if ((seg_en & (seg_en + 1'b1)) != 0) viol++;
            for (int k = 1; k < N; k++)
                if (seg_en[k] && !prev_en[k] && !prev_ack[k-1]) viol++;
            if (iso_en == 0 && !dom_ready) viol++;
            if (restore) begin
                rcount++;
                if (!(iso_en && seg_en == 4'hF)) rest_ok = 0;
            end
            if (dom_ready) begin
                seen = 1;
                check(prev_rest && !iso_en, {"R5 release after restore ", tag},
                      32'({prev_rest, iso_en}), 32'h2);
            end else begin
                prev_rest = restore;
                prev_en = seg_en; prev_ack = seg_ack;
                if (inject && c == 2) sleep_req = 1;
                tick();
                sleep_req = 0;
            end
        end
        check(seen, {"R5 domain ready ", tag}, 32'(seen), 1);
        check(viol == 0, {"R4 daisy order ", tag}, 32'(viol), 0);
        check(rcount == 1 && rest_ok, {"R5 one restore ", tag}, 32'(rcount), 1);
        check(!fault, {"R6 no fault ", tag}, 32'(fault), 0);
        tick();
        if (inject)
            check(iso_en && !dom_ready, "R8 held sleep starts shutdown",
                  32'(iso_en), 1);
        else
            check(!iso_en && dom_ready, "R8 stays on without request",
                  32'(iso_en), 0);
    endtask

    task automatic t_ignore();
        wake_req = 1; tick(); wake_req = 0; tick(); tick();
        check(seg_en == 4'hF && !iso_en && dom_ready, "R9 wake ignored in ON",
              32'({iso_en, seg_en}), 32'hF);
        t_shutdown();
        sleep_req = 1; tick(); sleep_req = 0;
        for (int c = 0; c < 3; c++) begin
            check(seg_en == 0 && iso_en && !save, "R9 sleep ignored in OFF",
                  32'({iso_en, save, seg_en}), 32'h20);
            tick();
        end
    endtask

    // From OFF; expects fault on the (lim+1)th negedge after seg watch enables.
    task automatic t_fault(input int dead, input int lim, input int dly,
                           input int watch, input logic [N-1:0] frozen);
        int cnt = 0;
        bit started = 0, rst_seen = 0;
        dead_seg = dead; ack_limit = LW'(lim); ack_dly = dly;
        wake_req = 1; tick(); wake_req = 0;
        for (int c = 0; c < 200 && !fault; c++) begin
            if (seg_en[watch]) started = 1;
            if (started) cnt++;
            if (restore) rst_seen = 1;
            if (!fault) tick();
        end
        check(fault && cnt == lim + 1, "R6 fault edge", 32'(cnt), 32'(lim + 1));
        check(seg_en == frozen && !rst_seen, "R6 frozen switches",
              32'(seg_en), 32'(frozen));
        sleep_req = 1; wake_req = 1;
        repeat (4) tick();
        sleep_req = 0; wake_req = 0;
        check(fault && seg_en == frozen && iso_en, "R6 fault sticky",
              32'({fault, seg_en}), 32'({1'b1, frozen}));
        dead_seg = -1;
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        t_shutdown();
        t_wake(0, "plain");
        t_shutdown();
        t_wake(1, "with sleep");
        repeat (3) tick();           // held request completes shutdown
        check(seg_en == 0 && iso_en, "R8 domain off after held sleep",
              32'(seg_en), 0);
        ack_limit = 8'd3; ack_dly = 3;
        t_wake(0, "ack at limit");   // R6 boundary: ack on the expiry edge
        t_ignore();
        t_fault(-1, 3, 4, 0, 4'b0001);
        do_reset();
        t_shutdown();
        t_fault(2, 5, 1, 2, 4'b0111);
        do_reset();
        t_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule